// File: doc/BRIEF.md
# Bus-Mapped Iterative CORDIC Sine/Cosine Peripheral

This peripheral sits on an AHB-Lite slave port and contains a rotation-mode CORDIC engine that works one step at a time. Software clears the start bit, loads an X and Y vector in Q1.30 format and a 32-bit binary angle, then sets the start bit. The engine rotates the vector by the angle, one micro-rotation per clock, while software polls a done flag. It then reads back the rotated X and Y and the leftover angle. The angle scale puts a full turn at 2^32, so π/3 is 715827883. Q1.30 puts 1.0 at 1073741824.

The engine first brings the angle into the ±π/2 half-plane. For angles in the second and third quadrants it negates the vector and adds half a turn to the angle. It then runs a fixed number of micro-rotations against a constant arctangent table. The CORDIC gain (about 1.6468) is left in the results. Loading X with about 0.6073 in Q1.30 and Y with 0 therefore gives the cosine in the X result and the sine in the Y result. The X, Y and Z result registers are the engine's working registers, so they move while a computation runs and hold once it ends.

Top module: `cordic_sincos_periph`

## Requirements
- R1: Every transfer completes with zero wait states (hreadyout stays 1) and an OKAY response (hresp 0).
- R2: Word offsets are 0x00 start (bit 0), 0x04 X operand, 0x08 Y operand, 0x0C angle operand, 0x10 done (bit 0), 0x14 X result, 0x18 Y result and 0x1C angle result. The start and operand registers read back the last value written. Writes to the done and result offsets have no effect.
- R3: Writing start bit 0 as 1 while it holds 0 and the engine is idle launches one computation. From the first read after that write until the computation ends, done reads 0.
- R4: Writing 1 to the start register while it already holds 1 launches nothing. Done stays 1 and the results stay unchanged.
- R5: Writes to the X, Y and angle operand registers made while a computation runs are ignored.
- R6: Done reads 1 no later than 40 clocks after the launching write. After that the results hold their values until the next launch.
- R7: With X = 652032874 (0.6073 in Q1.30) and Y = 0, the X result is within 256 LSB of cos(θ)·2^30 and the Y result is within 256 LSB of sin(θ)·2^30, for angles in all four quadrants. The angle result ends within 64 LSB of zero.
- R8: For a general vector, the results are within 256 LSB of 1.64676 times the vector rotated by θ.
- R9: After reset, every register in the window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address, offset from the instance base |
| htrans | input | 2 | Transfer type; NONSEQ and SEQ start a transfer |
| hwrite | input | 1 | 1 for a write transfer |
| hready | input | 1 | Bus-ready input; an address phase is taken only when it is 1 |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data (data phase) |
| hreadyout | output | 1 | Transfer-done output, always 1 |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
A wrong iteration count, a wrong table entry or a missed quadrant fold leaves the end values of the working registers far outside the tolerance. The bench sweeps sixteen angles spread over the full turn, plus general vectors, so this shows up at the first result read after done. A faulty start edge detector or a faulty busy gate shows up at the poll right after the launching write, or at an operand read-back once done rises. Both of those happen within about 40 clocks of the faulty access.

// File: rtl/cordic_sincos_pkg.sv
// Shared definitions for the CORDIC peripheral: register selectors and
// the arctangent table in binary-angle units (a full turn is 2^32).
package cordic_sincos_pkg;

    localparam int ANGLE_W   = 32;
    localparam int TABLE_LEN = 30;

    // Word selector taken from address bits [4:2].
    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_XIN   = 3'd1,
        SEL_YIN   = 3'd2,
        SEL_ZIN   = 3'd3,
        SEL_DONE  = 3'd4,
        SEL_XOUT  = 3'd5,
        SEL_YOUT  = 3'd6,
        SEL_ZOUT  = 3'd7
    } sel_e;

    // atan(2^-i) * 2^32 / (2*pi), rounded to the nearest integer.
    function automatic logic [ANGLE_W-1:0] atan_step(input int idx);
        case (idx)
            0:  atan_step = 32'd536870912;
            1:  atan_step = 32'd316933406;
            2:  atan_step = 32'd167458907;
            3:  atan_step = 32'd85004756;
            4:  atan_step = 32'd42667331;
            5:  atan_step = 32'd21354465;
            6:  atan_step = 32'd10679838;
            7:  atan_step = 32'd5340245;
            8:  atan_step = 32'd2670163;
            9:  atan_step = 32'd1335087;
            10: atan_step = 32'd667544;
            11: atan_step = 32'd333772;
            12: atan_step = 32'd166886;
            13: atan_step = 32'd83443;
            14: atan_step = 32'd41722;
            15: atan_step = 32'd20861;
            16: atan_step = 32'd10430;
            17: atan_step = 32'd5215;
            18: atan_step = 32'd2608;
            19: atan_step = 32'd1304;
            20: atan_step = 32'd652;
            21: atan_step = 32'd326;
            22: atan_step = 32'd163;
            23: atan_step = 32'd81;
            24: atan_step = 32'd41;
            25: atan_step = 32'd20;
            26: atan_step = 32'd10;
            27: atan_step = 32'd5;
            28: atan_step = 32'd3;
            29: atan_step = 32'd1;
            default: atan_step = '0;
        endcase
    endfunction

endpackage

// File: rtl/cordic_bus_regs.sv
// AHB-Lite slave front end and register file.
// Assumes: word accesses only. A misaligned address or one beyond the
// eight-word window is accepted with OKAY, reads as 0 and writes nothing.
// Drives a one-cycle launch pulse when start bit 0 goes from 0 to 1 while
// the engine is idle. Operand writes are dropped while the engine is busy.
module cordic_bus_regs
    import cordic_sincos_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] res_x,
    input  logic [DATA_W-1:0] res_y,
    input  logic [DATA_W-1:0] res_z,
    output logic [DATA_W-1:0] op_x,
    output logic [DATA_W-1:0] op_y,
    output logic [DATA_W-1:0] op_z,
    output logic              launch
);

    localparam int WIN_LSB = 5;

    logic       in_window;
    logic       take;
    logic       dp_wr;
    logic       dp_rd;
    sel_e       dp_sel;
    logic       start_q;
    logic       wr_start;

    // Address decode: aligned and inside the eight-word window.
    always_comb begin
        in_window = (haddr[1:0] == 2'b00) && (haddr[ADDR_W-1:WIN_LSB] == '0);
        take      = hsel && hready && (htrans == 2'b10 || htrans == 2'b11);
    end

    // Register the address phase for use in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_wr  <= 1'b0;
            dp_rd  <= 1'b0;
            dp_sel <= SEL_START;
        end else begin
            dp_wr  <= take && hwrite && in_window;
            dp_rd  <= take && !hwrite && in_window;
            dp_sel <= sel_e'(haddr[4:2]);
        end
    end

    // Start edge detect: a launch needs the stored bit at 0 and an idle engine.
    always_comb begin
        wr_start = dp_wr && (dp_sel == SEL_START);
        launch   = wr_start && hwdata[0] && !start_q && !busy;
    end

    // Start bit and operand storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            op_x    <= '0;
            op_y    <= '0;
            op_z    <= '0;
        end else begin
            if (wr_start) start_q <= hwdata[0];
            if (dp_wr && !busy) begin
                if (dp_sel == SEL_XIN) op_x <= hwdata;
                if (dp_sel == SEL_YIN) op_y <= hwdata;
                if (dp_sel == SEL_ZIN) op_z <= hwdata;
            end
        end
    end

    // Data-phase read mux.
    always_comb begin
        hrdata = '0;
        if (dp_rd) begin
            case (dp_sel)
                SEL_START: hrdata = {{(DATA_W-1){1'b0}}, start_q};
                SEL_XIN:   hrdata = op_x;
                SEL_YIN:   hrdata = op_y;
                SEL_ZIN:   hrdata = op_z;
                SEL_DONE:  hrdata = {{(DATA_W-1){1'b0}}, done};
                SEL_XOUT:  hrdata = res_x;
                SEL_YOUT:  hrdata = res_y;
                SEL_ZOUT:  hrdata = res_z;
                default:   hrdata = '0;
            endcase
        end
    end

    // Zero wait states, always OKAY.
    always_comb begin
        hreadyout = 1'b1;
        hresp     = 1'b0;
    end

    // Operands stay frozen while the engine runs.
    p_ops_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(op_x) && $stable(op_y) && $stable(op_z)));

endmodule

// File: rtl/cordic_iter_engine.sv
// Iterative rotation-mode CORDIC datapath, one micro-rotation per clock.
// Assumes: launch is a single-cycle pulse given only while idle. Q1.30 vector
// operands, 32-bit binary angle. Results carry the CORDIC gain (no scaling).
module cordic_iter_engine
    import cordic_sincos_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ITERS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] op_x,
    input  logic [DATA_W-1:0] op_y,
    input  logic [DATA_W-1:0] op_z,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_x,
    output logic [DATA_W-1:0] res_y,
    output logic [DATA_W-1:0] res_z
);

    localparam int CNT_W = $clog2(ITERS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    logic signed [DATA_W-1:0] x_q, y_q, z_q;
    logic signed [DATA_W-1:0] x0, y0, z0;
    logic signed [DATA_W-1:0] x_sh, y_sh;
    logic signed [DATA_W-1:0] x_nx, y_nx, z_nx;
    logic [DATA_W-1:0]        ang;
    logic [CNT_W-1:0]         step;
    logic                     flip;

    // Quadrant fold: angles in quadrants II and III negate the vector and
    // add half a turn to the angle.
    always_comb begin
        flip = (op_z[DATA_W-1] != op_z[DATA_W-2]);
        x0   = flip ? -$signed(op_x) : $signed(op_x);
        y0   = flip ? -$signed(op_y) : $signed(op_y);
        z0   = flip ? $signed({~op_z[DATA_W-1], op_z[DATA_W-2:0]}) : $signed(op_z);
    end

    // One micro-rotation, steered by the sign of the leftover angle.
    always_comb begin
        x_sh = x_q >>> step;
        y_sh = y_q >>> step;
        ang  = atan_step(int'(step));
        if (!z_q[DATA_W-1]) begin
            x_nx = x_q - y_sh;
            y_nx = y_q + x_sh;
            z_nx = z_q - $signed(ang);
        end else begin
            x_nx = x_q + y_sh;
            y_nx = y_q - x_sh;
            z_nx = z_q + $signed(ang);
        end
    end

    // Working registers, step counter and the busy/done handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            y_q  <= '0;
            z_q  <= '0;
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (launch) begin
            x_q  <= x0;
            y_q  <= y0;
            z_q  <= z0;
            step <= '0;
            busy <= 1'b1;
            done <= 1'b0;
        end else if (busy) begin
            x_q  <= x_nx;
            y_q  <= y_nx;
            z_q  <= z_nx;
            step <= step + 1'b1;
            if (step == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assign res_x = x_q;
    assign res_y = y_q;
    assign res_z = z_q;

    // A launch clears done and starts the run in the next cycle.
    p_launch_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !done));

    // Done and busy are never high together.
    p_done_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // Done rises only at the end of a run.
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // Results hold while the engine is idle and no launch arrives.
    p_results_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !launch) |=> ($stable(res_x) && $stable(res_y) && $stable(res_z)));

endmodule

// File: rtl/cordic_sincos_periph.sv
// Top level: AHB-Lite register front end plus one iterative CORDIC engine.
// Assumes: a single 32-bit data bus. haddr is the offset from the instance base.
module cordic_sincos_periph
    import cordic_sincos_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ITERS  = TABLE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    input  logic [31:0]       hwdata,
    output logic [31:0]       hrdata,
    output logic              hreadyout,
    output logic              hresp
);

    localparam int DATA_W = ANGLE_W;

    logic              busy, done, launch;
    logic [DATA_W-1:0] op_x, op_y, op_z;
    logic [DATA_W-1:0] res_x, res_y, res_z;

    cordic_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hready(hready), .hwdata(hwdata),
        .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
        .busy(busy), .done(done), .res_x(res_x), .res_y(res_y), .res_z(res_z),
        .op_x(op_x), .op_y(op_y), .op_z(op_z), .launch(launch)
    );

    cordic_iter_engine #(.DATA_W(DATA_W), .ITERS(ITERS)) u_engine (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .op_x(op_x), .op_y(op_y), .op_z(op_z),
        .busy(busy), .done(done), .res_x(res_x), .res_y(res_y), .res_z(res_z)
    );

endmodule

// File: tb/cordic_sincos_periph_test.sv
// Self-checking bench: angle sweep over the full turn, general vectors and
// the start/busy handshake corner cases. Expected values come from real math.
module cordic_sincos_periph_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 100000;
    localparam real TWO_PI     = 6.283185307179586;
    localparam real GAIN       = 1.6467602581210654;
    localparam real ONE_Q30    = 1073741824.0;
    localparam int  K_Q30      = 652032874;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [7:0]  haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic        hready = 1'b1;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_sincos_periph uut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp)
    );

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_near(string req, logic [31:0] act, real exp, real tol);
        real d;
        checks++;
        d = $itor($signed(act)) - exp;
        if (d > tol || d < -tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0.1f", req, $signed(act), exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = a;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = a;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        d = hrdata;
    endtask

    // Launch and wait: first poll must read 0 (R3), done within 40 clocks (R6).
    task automatic launch_wait(string tag);
        logic [31:0] v;
        int polls;
        bus_write(8'h00, 32'd1);
        bus_read(8'h10, v);
        check_eq({"R3 done low after launch ", tag}, v, 32'd0);
        polls = 1;
        while (v[0] !== 1'b1 && polls < 20) begin
            bus_read(8'h10, v);
            polls++;
        end
        check_eq({"R6 done within bound ", tag}, {31'd0, v[0]}, 32'd1);
    endtask

    task automatic run_rotation(string req, int x, int y, int z);
        logic [31:0] rx, ry, rz;
        real th, ex, ey;
        bus_write(8'h00, 32'd0);
        bus_write(8'h04, x);
        bus_write(8'h08, y);
        bus_write(8'h0C, z);
        launch_wait(req);
        bus_read(8'h14, rx);
        bus_read(8'h18, ry);
        bus_read(8'h1C, rz);
        th = $itor(z) * TWO_PI / 4294967296.0;
        ex = GAIN * ($itor(x) * $cos(th) - $itor(y) * $sin(th));
        ey = GAIN * ($itor(x) * $sin(th) + $itor(y) * $cos(th));
        check_near({req, " x result"}, rx, ex, 256.0);
        check_near({req, " y result"}, ry, ey, 256.0);
        check_near({req, " angle residual"}, rz, 0.0, 64.0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, keep;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state of all eight words; R1 response checks.
        for (int i = 0; i < 8; i++) begin
            bus_read(8'(i * 4), v);
            check_eq("R9 reset value", v, 32'd0);
        end
        check_eq("R1 hreadyout", {31'd0, hreadyout}, 32'd1);
        check_eq("R1 hresp okay", {31'd0, hresp}, 32'd0);

        // R2: read-back of the operand words, writes to read-only words ignored.
        bus_write(8'h04, 32'h1234_5678);
        bus_write(8'h08, 32'h9abc_def0);
        bus_write(8'h0C, 32'h0f0f_0f0f);
        bus_read(8'h04, v); check_eq("R2 x readback", v, 32'h1234_5678);
        bus_read(8'h08, v); check_eq("R2 y readback", v, 32'h9abc_def0);
        bus_read(8'h0C, v); check_eq("R2 z readback", v, 32'h0f0f_0f0f);
        bus_write(8'h14, 32'hdead_beef);
        bus_write(8'h10, 32'h1);
        bus_read(8'h14, v); check_eq("R2 result word write ignored", v, 32'd0);
        bus_read(8'h10, v); check_eq("R2 done word write ignored", v, 32'd0);

        // R7: sixteen angles spread over the whole turn, plus pi/3.
        for (int k = 0; k < 16; k++)
            run_rotation("R7 sweep", K_Q30, 0, int'(k * 32'h1000_0000 + 32'h0123_4567));
        run_rotation("R7 pi/3", K_Q30, 0, 715827883);
        run_rotation("R7 quarter turn", K_Q30, 0, 32'h4000_0000);

        // R8: general vectors.
        run_rotation("R8 vector a", int'(0.3 * ONE_Q30), int'(-0.2 * ONE_Q30), 32'h2aaa_aaab);
        run_rotation("R8 vector b", int'(-0.25 * ONE_Q30), int'(0.35 * ONE_Q30), int'(32'hb000_0000));
        run_rotation("R8 vector c", int'(0.1 * ONE_Q30), int'(0.4 * ONE_Q30), int'(32'hd555_5555));

        // R6: results hold after done.
        bus_read(8'h14, keep);
        repeat (10) @(posedge clk);
        bus_read(8'h14, v);
        check_eq("R6 results hold", v, keep);

        // R4: writing 1 again while start already 1 launches nothing.
        bus_write(8'h00, 32'd1);
        bus_read(8'h10, v);
        check_eq("R4 done stays high", v, 32'd1);
        bus_read(8'h14, v);
        check_eq("R4 result unchanged", v, keep);

        // R5: operand writes during a run are ignored.
        bus_write(8'h00, 32'd0);
        bus_write(8'h04, K_Q30);
        bus_write(8'h08, 32'd0);
        bus_write(8'h0C, 32'd0);
        bus_write(8'h00, 32'd1);
        bus_write(8'h04, 32'h7777_7777);
        bus_write(8'h0C, 32'h5555_5555);
        repeat (40) @(posedge clk);
        bus_read(8'h04, v); check_eq("R5 x operand kept", v, K_Q30);
        bus_read(8'h0C, v); check_eq("R5 z operand kept", v, 32'd0);
        bus_read(8'h18, v); check_near("R5 y result for zero angle", v, 0.0, 256.0);
        check_eq("R1 hresp okay end", {31'd0, hresp}, 32'd0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule